// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a multi-register memory transfer one word at a time. A request carries a 16-bit register selection mask, a 32-bit base address and four control bits: pre/post indexing, up/down direction, base writeback and load/store. Once the request is taken, the block issues one word access per selected register. Each access gives the register index and the word address. The memory side answers each access with a ready handshake. When the last access has been taken, the block pulses a completion strobe and reports the updated base value.

The lowest word address is computed from the number of selected registers, whichever of the four indexing modes is chosen. Registers are always visited from the lowest index to the highest and the address always climbs by 4. The memory image therefore has the same layout in every mode. Only the start address and the written-back base depend on the direction bit.

Both edges are valid/ready. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the block is idle, so a requester must hold its request until then. An access is offered with `mem_valid`. Its address, index and flags stay frozen until a cycle with `mem_ready` high; that cycle retires the access. `mem_valid` never depends on `mem_ready`. The block carries no data: it only flags the access whose store data must be the program counter plus 4.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1 and `busy`, `mem_valid`, `done` are all 0.
- R2: A request performs exactly as many retired accesses as there are set bits in `req_list`.
- R3: Accesses visit the selected indices in ascending order. The k-th retired access (k from 0) uses address start+4k.
- R4: The start address depends on `req_pre` and `req_up`, with n the number of set bits:
  - `req_up`=1, `req_pre`=1: base+4.
  - `req_up`=1, `req_pre`=0: base.
  - `req_up`=0, `req_pre`=1: base−4n.
  - `req_up`=0, `req_pre`=0: base−4n+4.
- R5: Bits [1:0] of every access address are 0. The start address is the R4 value with its two low bits cleared.
- R6: On the `done` cycle, `wb_en` equals the request's `req_wb`. `wb_base` is base+4n when `req_up`=1 and base−4n when `req_up`=0 if `req_wb`=1, and the unchanged base if `req_wb`=0.
- R7: `mem_pc_fix`=1 exactly on an offered access that is a store (`mem_load`=0) of index 15. `mem_load` equals the request's `req_load` on every access.
- R8: A request is taken only when idle. `req_ready`=0 from the cycle after acceptance through the `done` cycle, and a request held during a run does not alter that run.
- R9: An access that is not acknowledged stays offered with unchanged address and index.
- R10: An empty `req_list` produces no access, and `done` is high in the cycle right after acceptance.
- R11: `busy`=1 from the cycle after acceptance through the `done` cycle. `done` lasts one cycle, and the cycle after it is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request (idle) |
| req_list | input | 16 | Register selection mask, bit i selects register i |
| req_base | input | 32 | Base address |
| req_pre | input | 1 | 1 = index before access, 0 = after |
| req_up | input | 1 | 1 = ascending base, 0 = descending |
| req_wb | input | 1 | 1 = report updated base |
| req_load | input | 1 | 1 = load, 0 = store |
| mem_valid | output | 1 | Word access offered |
| mem_ready | input | 1 | Access retired this cycle |
| mem_addr | output | 32 | Word address of the offered access |
| mem_idx | output | 4 | Register index of the offered access |
| mem_load | output | 1 | Offered access is a load |
| mem_pc_fix | output | 1 | Store of index 15: data must be PC+4 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| wb_en | output | 1 | Writeback requested, valid with done |
| wb_base | output | 32 | New base value, valid with done |

## Verification
Two events can meet on one cycle: the retirement of a run's last access and a new request that is already waiting at the request port. The bench keeps `req_valid` high with a different request's fields for the whole of a run. It checks that `req_ready` stays low through the `done` cycle and that the first run's addresses, count and writeback ignore the waiting fields. It then checks that the waiting request is taken on the first idle cycle and runs correctly. Random acknowledge gaps move the last retirement to different cycles, so back-pressure and completion are checked at many different timings.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  localparam int NREG = 16;
  localparam int AW   = 32;
  localparam int IDXW = $clog2(NREG);
  localparam int CNTW = $clog2(NREG + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/blkx_popcnt.sv
module blkx_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/blkx_lowbit.sv
module blkx_lowbit #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  rest
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    rest = vec & ~(N'(1) << idx);
  end
endmodule

// File: rtl/blkx_addr_calc.sv
module blkx_addr_calc #(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  input  logic          pre,
  input  logic          up,
  output logic [AW-1:0] start,
  output logic [AW-1:0] new_base
);
  logic [AW-1:0] span;
  logic [AW-1:0] raw;

  always_comb begin
    span = AW'({cnt, 2'b00});
    if (up) raw = pre ? base + AW'(4) : base;
    else    raw = pre ? base - span : base - span + AW'(4);
    start    = {raw[AW-1:2], 2'b00};
    new_base = up ? base + span : base - span;
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blkx_pkg::*;
#(
  parameter int N_REG  = NREG,
  parameter int ADDR_W = AW,
  localparam int IW = $clog2(N_REG),
  localparam int CW = $clog2(N_REG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [N_REG-1:0]  req_list,
  input  logic [ADDR_W-1:0] req_base,
  input  logic              req_pre,
  input  logic              req_up,
  input  logic              req_wb,
  input  logic              req_load,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IW-1:0]     mem_idx,
  output logic              mem_load,
  output logic              mem_pc_fix,
  output logic              busy,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_base
);
  seq_state_t        state_q;
  logic [N_REG-1:0]  mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic              load_q;
  logic              wb_q;
  logic [ADDR_W-1:0] wbv_q;

  logic [CW-1:0]     req_cnt;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] next_base;
  logic [IW-1:0]     cur_idx;
  logic [N_REG-1:0]  mask_rest;
  logic              take_req;
  logic              retire;

  blkx_popcnt #(.N(N_REG), .CW(CW)) u_pop (
    .vec(req_list), .cnt(req_cnt)
  );

  blkx_addr_calc #(.AW(ADDR_W), .CW(CW)) u_addr (
    .base(req_base), .cnt(req_cnt), .pre(req_pre), .up(req_up),
    .start(start_addr), .new_base(next_base)
  );

  blkx_lowbit #(.N(N_REG), .IW(IW)) u_pick (
    .vec(mask_q), .idx(cur_idx), .rest(mask_rest)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign take_req  = req_valid && req_ready;
  assign mem_valid = (state_q == ST_RUN);
  assign retire    = mem_valid && mem_ready;
  assign mem_addr  = addr_q;
  assign mem_idx   = cur_idx;
  assign mem_load  = load_q;
  assign mem_pc_fix = mem_valid && !load_q && (cur_idx == IW'(N_REG - 1));
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign wb_en     = wb_q;
  assign wb_base   = wbv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      load_q  <= 1'b0;
      wb_q    <= 1'b0;
      wbv_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take_req) begin
          mask_q  <= req_list;
          addr_q  <= start_addr;
          load_q  <= req_load;
          wb_q    <= req_wb;
          wbv_q   <= req_wb ? next_base : req_base;
          state_q <= (req_list == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (retire) begin
          mask_q <= mask_rest;
          addr_q <= addr_q + ADDR_W'(4);
          if (mask_rest == '0) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: offered access holds until retired
  a_r9_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_idx)));

  // R5: word alignment of every access
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R3: indices strictly ascend between consecutive accesses of a run
  a_r3_ascending_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || (mem_idx > $past(mem_idx))));

  // R11: done is a single-cycle strobe followed by idle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R8: no request taken while a run is active
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R10: an accepted empty list goes straight to completion
  a_r10_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && (req_list == '0)) |=> (done && !mem_valid));
endmodule

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_list = '0;
  logic [31:0] req_base = '0;
  logic        req_pre = 1'b0, req_up = 1'b0, req_wb = 1'b0, req_load = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_idx;
  logic        mem_load, mem_pc_fix, busy, done, wb_en;
  logic [31:0] wb_base;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_list(req_list), .req_base(req_base), .req_pre(req_pre), .req_up(req_up),
    .req_wb(req_wb), .req_load(req_load), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_idx(mem_idx),
    .mem_load(mem_load), .mem_pc_fix(mem_pc_fix), .busy(busy), .done(done),
    .wb_en(wb_en), .wb_base(wb_base)
  );

  function automatic int f_pop(logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [31:0] f_start(logic [31:0] b, int n, logic pre, logic up);
    logic [31:0] r;
    if (up) r = pre ? b + 32'd4 : b;
    else    r = pre ? b - 32'(4 * n) : b - 32'(4 * n) + 32'd4;
    return r & 32'hFFFF_FFFC;
  endfunction

  function automatic logic [31:0] f_wb(logic [31:0] b, int n, logic up, logic wb);
    if (!wb) return b;
    return up ? b + 32'(4 * n) : b - 32'(4 * n);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the done cycle.
  task automatic run(logic [15:0] lst, logic [31:0] b, logic pre, logic up,
                     logic wb, logic ld, bit hold,
                     logic [15:0] h_lst, logic [31:0] h_b);
    int n = f_pop(lst);
    logic [31:0] st = f_start(b, n, pre, up);
    logic [15:0] rem = lst;
    int k = 0;
    int cyc = 0;
    int eidx;
    req_list = lst; req_base = b; req_pre = pre; req_up = up;
    req_wb = wb; req_load = ld; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R8 ready when idle", 32'(req_ready), 32'd1);
    @(posedge clk); #1;
    if (hold) begin
      req_list = h_lst; req_base = h_b; req_pre = ~pre; req_up = ~up;
      req_wb = ~wb; req_load = ~ld;
    end else req_valid = 1'b0;
    @(negedge clk);
    if (lst == 16'h0)
      chk(done == 1'b1, "R10 empty list done next cycle", 32'(done), 32'd1);
    while (!done && cyc < 400) begin
      chk(busy == 1'b1, "R11 busy during run", 32'(busy), 32'd1);
      chk(req_ready == 1'b0, "R8 ready low while busy", 32'(req_ready), 32'd0);
      chk(mem_valid == 1'b1, "R2 access offered while list remains", 32'(mem_valid), 32'd1);
      eidx = 0;
      for (int i = 15; i >= 0; i--) if (rem[i]) eidx = i;
      chk(mem_idx == 4'(eidx), "R3 ascending index", 32'(mem_idx), 32'(eidx));
      chk(mem_addr == st + 32'(4 * k), "R4 R3 access address", mem_addr, st + 32'(4 * k));
      chk(mem_addr[1:0] == 2'b00, "R5 alignment", mem_addr, mem_addr & 32'hFFFF_FFFC);
      chk(mem_load == ld, "R7 load flag", 32'(mem_load), 32'(ld));
      chk(mem_pc_fix == (!ld && eidx == 15), "R7 pc fix flag", 32'(mem_pc_fix),
          32'(!ld && eidx == 15));
      mem_ready = ($urandom % 3) != 0;
      if (mem_ready) begin
        rem[eidx] = 1'b0;
        k++;
      end
      @(posedge clk); #1;
      mem_ready = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R11 done reached", 32'(done), 32'd1);
    chk(busy == 1'b1, "R11 busy in done cycle", 32'(busy), 32'd1);
    chk(req_ready == 1'b0, "R8 ready low in done cycle", 32'(req_ready), 32'd0);
    chk(mem_valid == 1'b0, "R2 no access on done", 32'(mem_valid), 32'd0);
    chk(k == n, "R2 access count", 32'(k), 32'(n));
    chk(wb_en == wb, "R6 writeback enable", 32'(wb_en), 32'(wb));
    chk(wb_base == f_wb(b, n, up, wb), "R6 writeback base", wb_base, f_wb(b, n, up, wb));
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11 idle after done", {30'd0, done, busy}, 32'd0);
    chk(req_ready == 1'b1, "R8 ready after done", 32'(req_ready), 32'd1);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0 && mem_valid == 1'b0 && done == 1'b0,
        "R1 reset state", {28'd0, req_ready, busy, mem_valid, done}, 32'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0, "R1 idle after reset release",
        {30'd0, req_ready, busy}, 32'b10);

    // Directed: all four modes on one list
    run(16'h8421, 32'h0000_1000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0);
    run(16'h8421, 32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    run(16'h8421, 32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0);
    run(16'h8421, 32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    // R10 empty list, with and without writeback
    run(16'h0000, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    run(16'h0000, 32'h0000_2000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0);
    // R5 unaligned base, full list, store of index 15 (R7)
    run(16'hFFFF, 32'h0000_3003, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
    run(16'h8000, 32'h0000_0002, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, '0, '0);
    // R6 wrap around zero going down
    run(16'h0003, 32'h0000_0004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0);
    // R8 request waiting through a run, then taken when idle
    run(16'h0F0F, 32'h0000_4000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h00F0, 32'h0000_8000);
    run(16'h00F0, 32'h0000_8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);

    for (int t = 0; t < 60; t++) begin
      logic [15:0] l = 16'($urandom);
      if (t % 7 == 0) l = l & 16'($urandom);
      run(l, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          1'b0, '0, '0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule